// File: doc/BRIEF.md
# Four-Way Parallel Bus Arbiter with Ownership Hold

This block decides which of four processor-side masters may drive a shared system bus. Each master raises a request line and waits for its own acknowledge. The request lines feed a fixed-priority encoder. The encoder produces a two-bit index and a valid flag. A decoder turns that index back into a single acknowledge. The winner's acknowledge is registered. At the same edge a shared busy flag is set, so ownership stays put while the transfer runs.

The owner keeps the bus for as long as it holds its request. When it lowers the request, busy and its acknowledge both clear on the next clock edge. The remaining requests are arbitrated one edge after that. While the bus is owned, a common-request output tells the owner whether any other master is waiting, so the owner can choose to give the bus up early. All state changes on one bus clock. Wired-OR bus lines are modelled as ordinary logic.

Top module: `bus_arbiter_par`

## Requirements
- R1: While `rst_ni` is low, `ack_o`, `busy_o` and `cbrq_o` are all 0, and asserting `rst_ni` low clears them without waiting for a clock edge.
- R2: From idle (`busy_o` low), a single active request on line k leads, after the next rising edge, to `ack_o` = one-hot bit k and `busy_o` = 1.
- R3: Bit 0 of `req_i` has the highest priority and bit 3 the lowest. With several requests active on an idle edge, only the lowest-numbered active line is acknowledged.
- R4: On an idle edge with `req_i` = 0, `busy_o` stays 0 and `ack_o` stays 0.
- R5: While `busy_o` is high and the owner keeps its request, new requests of any priority do not change `ack_o`, and `busy_o` stays 1.
- R6: When the owner's request is low at a rising edge while `busy_o` is high, `busy_o` and `ack_o` are both 0 after that edge, even if other lines are requesting.
- R7: After a release, the next rising edge grants the highest-priority request still active, by the rule of R3.
- R8: `cbrq_o` is 1 exactly when `busy_o` is 1 and some line whose acknowledge is low has its request high. It is 0 whenever the bus is idle.
- R9: In every cycle at most one bit of `ack_o` is 1, and `ack_o` is nonzero only while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request lines, bit 0 highest priority |
| ack_o | output | 4 | Registered one-hot acknowledge |
| busy_o | output | 1 | Bus owned flag |
| cbrq_o | output | 1 | Another master is waiting while the bus is owned |

## Verification
The bench aims at simultaneous requests on an idle edge. A reversed or broken encoder would acknowledge a lower-priority line or more than one line. It raises a higher-priority request while the bus is owned, which catches a design that grants afresh every cycle and steals the bus. It drops the owner's request while others wait, so a design that hands the bus over in the same edge, or keeps the old acknowledge for an extra cycle, shows up as a wrong value in the release or re-arbitration cycle. It also checks the common-request line in the idle, contended and uncontended cases, and clears the state with reset in the middle of a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_MASTERS = 4;
  localparam int unsigned IDX_W = $clog2(NUM_MASTERS);

  typedef logic [NUM_MASTERS-1:0] req_vec_t;
  typedef logic [IDX_W-1:0]       idx_t;

  typedef struct packed {
    logic busy;
    idx_t owner;
  } own_state_t;
endpackage

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
  parameter int unsigned N_IN  = 4,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  // descending scan so the lowest set index is the last to assign
  always_comb begin
    idx_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/arb_idx_dec.sv
module arb_idx_dec #(
  parameter int unsigned N_OUT = 4,
  localparam int unsigned IDX_W = $clog2(N_OUT)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [N_OUT-1:0] onehot_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_line
    assign onehot_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/arb_own_ctrl.sv
module arb_own_ctrl #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             win_valid_i,
  input  logic [N_REQ-1:0] win_onehot_i,
  output logic [N_REQ-1:0] ack_o,
  output logic             busy_o
);
  logic [N_REQ-1:0] ack_q;
  logic             busy_q;
  logic [IDX_W-1:0] owner_q;
  logic             owner_holds;

  assign owner_holds = req_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= '0;
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (!busy_q) begin
      if (win_valid_i) begin
        ack_q   <= win_onehot_i;
        busy_q  <= 1'b1;
        owner_q <= win_idx_i;
      end
    end else if (!owner_holds) begin
      // release edge; arbitration resumes one edge later
      ack_q  <= '0;
      busy_q <= 1'b0;
    end
  end

  assign ack_o  = ack_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/bus_arbiter_par.sv
module bus_arbiter_par #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] ack_o,
  output logic             busy_o,
  output logic             cbrq_o
);
  logic [IDX_W-1:0] win_idx;
  logic             win_valid;
  logic [N_REQ-1:0] win_onehot;

  arb_prio_enc #(.N_IN(N_REQ)) u_enc (
    .req_i   (req_i),
    .idx_o   (win_idx),
    .valid_o (win_valid)
  );

  arb_idx_dec #(.N_OUT(N_REQ)) u_dec (
    .idx_i    (win_idx),
    .en_i     (win_valid),
    .onehot_o (win_onehot)
  );

  arb_own_ctrl #(.N_REQ(N_REQ)) u_own (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .win_idx_i    (win_idx),
    .win_valid_i  (win_valid),
    .win_onehot_i (win_onehot),
    .ack_o        (ack_o),
    .busy_o       (busy_o)
  );

  // wired-OR of waiting non-owners
  assign cbrq_o = busy_o && |(req_i & ~ack_o);
endmodule

// File: rtl/bus_arbiter_par_chk.sv
module bus_arbiter_par_chk #(
  parameter int unsigned N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic [N_REQ-1:0] ack_o,
  input logic             busy_o,
  input logic             cbrq_o
);
  assert_ack_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  assert_ack_needs_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |-> busy_o);

  assert_grant_lowest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i != '0) |=>
      (busy_o && ack_o == $past(req_i & (~req_i + N_REQ'(1)))));

  assert_idle_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i == '0) |=> (!busy_o && ack_o == '0));

  assert_hold_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && |(req_i & ack_o)) |=> (busy_o && $stable(ack_o)));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(|(req_i & ack_o))) |=> (!busy_o && ack_o == '0));

  assert_cbrq_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cbrq_o);
endmodule

bind bus_arbiter_par bus_arbiter_par_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .ack_o  (ack_o),
  .busy_o (busy_o),
  .cbrq_o (cbrq_o)
);

// File: tb/sim_bus_arbiter_par.sv
`timescale 1ns/1ps
module sim_bus_arbiter_par;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = 4'b0;
  logic [3:0] ack_o;
  logic       busy_o;
  logic       cbrq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_arbiter_par u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ack_o  (ack_o),
    .busy_o (busy_o),
    .cbrq_o (cbrq_o)
  );

  task automatic chk(string req, logic [3:0] a_exp, logic b_exp, logic c_exp);
    n_chk++;
    if (ack_o !== a_exp || busy_o !== b_exp || cbrq_o !== c_exp) begin
      n_bad++;
      $display("FAIL %s: ack=%b busy=%b cbrq=%b expected ack=%b busy=%b cbrq=%b",
               req, ack_o, busy_o, cbrq_o, a_exp, b_exp, c_exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic settle_idle();
    req_i = 4'b0;
    step();
    step();
  endtask

  // R9 every cycle
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (!$onehot0(ack_o) || (ack_o != 4'b0 && !busy_o)) begin
        n_bad++;
        $display("FAIL R9: ack=%b busy=%b expected onehot0 ack gated by busy", ack_o, busy_o);
      end
    end
  end

  task automatic t_reset();
    chk("R1 in reset", 4'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    step();
    req_i = 4'b0100;
    step();
    chk("R2 grant before mid reset", 4'b0100, 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5 chk("R1 async clear", 4'b0, 1'b0, 1'b0);
    step();
    req_i = 4'b0;
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", 4'b0, 1'b0, 1'b0);
  endtask

  task automatic t_idle();
    req_i = 4'b0;
    step();
    step();
    chk("R4 no request", 4'b0, 1'b0, 1'b0);
  endtask

  task automatic t_single();
    for (int k = 0; k < 4; k++) begin
      req_i = 4'b1 << k;
      step();
      chk("R2 single request", 4'b1 << k, 1'b1, 1'b0);
      settle_idle();
    end
  endtask

  task automatic t_priority();
    req_i = 4'b1110;
    step();
    chk("R3 lowest of 1110", 4'b0010, 1'b1, 1'b1);
    settle_idle();
    req_i = 4'b1111;
    step();
    chk("R3 lowest of 1111", 4'b0001, 1'b1, 1'b1);
    settle_idle();
    req_i = 4'b1100;
    step();
    chk("R3 lowest of 1100", 4'b0100, 1'b1, 1'b1);
    settle_idle();
  endtask

  task automatic t_hold();
    req_i = 4'b0100;
    step();
    chk("R8 owner alone", 4'b0100, 1'b1, 1'b0);
    req_i = 4'b0101;
    step();
    chk("R5 higher request held off", 4'b0100, 1'b1, 1'b1);
    step();
    chk("R5 still held", 4'b0100, 1'b1, 1'b1);
    req_i = 4'b0001;
    step();
    chk("R6 release", 4'b0, 1'b0, 1'b0);
    step();
    chk("R7 rearbitrate", 4'b0001, 1'b1, 1'b0);
    settle_idle();
  endtask

  task automatic t_release();
    req_i = 4'b1011;
    step();
    chk("R8 contention", 4'b0001, 1'b1, 1'b1);
    req_i = 4'b1010;
    step();
    chk("R6 release with waiters", 4'b0, 1'b0, 1'b0);
    step();
    chk("R7 next winner", 4'b0010, 1'b1, 1'b1);
    req_i = 4'b1000;
    step();
    chk("R6 second release", 4'b0, 1'b0, 1'b0);
    step();
    chk("R7 last winner", 4'b1000, 1'b1, 1'b0);
    settle_idle();
    chk("R4 idle at end", 4'b0, 1'b0, 1'b0);
  endtask

  initial begin
    step();
    step();
    t_reset();
    t_idle();
    t_single();
    t_priority();
    t_hold();
    t_release();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule